// File: doc/BRIEF.md
# Backplane Transfer Cycle Timeout Monitor

This block watches data-transfer cycles on a VMEbus-style backplane and answers with a bus-error response when a cycle is still open after 128 microseconds. A cycle is open while the address strobe and at least one data strobe are low. The cycle is closed normally by the responder's data acknowledge, or by a bus error that some other board drives. If neither arrives in time, the monitor pulls its active-low bus-error output low. It keeps that output low until the master lets go of its strobes.

A bit in a local control/status register enables the monitor. Each bus error that the monitor raises itself also sets a sticky timeout flag. Software can use that flag to tell the monitor's own bus errors apart from those driven by other boards. Software clears the flag with a one-cycle strobe. The timeout is given in clock cycles as the product of the parameters `TIMEOUT_US` and `CLK_MHZ`.

The control is a four-state machine:
- `MON_IDLE`: no cycle is open.
- `MON_TIMING`: an enabled cycle is being counted.
- `MON_HOLD`: the cycle was acknowledged, ended by another board's bus error, or started or continued while the monitor was disabled. The block waits here for the strobes to be released.
- `MON_BERR`: the monitor is driving its bus error.

The transitions are:
- `MON_IDLE` to `MON_TIMING` when an enabled cycle opens with no termination present.
- `MON_IDLE` to `MON_HOLD` when a cycle opens already terminated, or while the monitor is disabled.
- `MON_TIMING` to `MON_IDLE` on strobe release.
- `MON_TIMING` to `MON_HOLD` on disable or on termination.
- `MON_TIMING` to `MON_BERR` when the limit is reached.
- `MON_HOLD` to `MON_IDLE` on release.
- `MON_BERR` to `MON_IDLE` on release.
- `MON_BERR` to `MON_HOLD` on disable.

Top module: `vme_cycle_watchdog`

## Requirements
- R1: After reset, `berr_out_n` is 1 and `timeout_flag` is 0.
- R2: If a cycle receives data acknowledge (`dtack_n` low) at or before its LIMIT-th clock edge, no bus error is produced and `timeout_flag` is unchanged. LIMIT = `TIMEOUT_US`*`CLK_MHZ`. The cycle's first edge is the first edge at which it is seen open.
- R3: If a cycle stays open with no termination for LIMIT edges, `berr_out_n` goes low immediately after its LIMIT-th edge. The cycle is open when `as_n` is 0 and at least one bit of `ds_n` is 0.
- R4: Once low, `berr_out_n` stays low while the cycle stays open, whatever `dtack_n` does. It returns to 1 one edge after the cycle closes, that is, when `as_n` goes to 1 or all `ds_n` bits go to 1.
- R5: `timeout_flag` becomes 1 at the same edge at which the monitor asserts `berr_out_n`. It then stays 1 until a `status_clear` pulse.
- R6: If `status_clear` and a new timeout happen at the same edge, `timeout_flag` ends up 1.
- R7: While `mon_enable` is 0, `berr_out_n` stays 1. Dropping `mon_enable` during a cycle stops that cycle's timing for good, even if the enable returns before the cycle ends. In that case `timeout_flag` is not set.
- R8: A bus error from another board (`berr_in_n` low) ends timing like an acknowledge. The monitor then produces no bus error and does not set the flag.
- R9: Data strobes without the address strobe, or the address strobe without any data strobe, are never timed.
- R10: Each new cycle is timed from zero, even when it follows another cycle back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | NUM_DS | Data strobes, active low |
| dtack_n | input | 1 | Data acknowledge from the responder, active low |
| berr_in_n | input | 1 | Bus error seen on the backplane from another source, active low |
| mon_enable | input | 1 | Monitor enable bit from the control/status register |
| status_clear | input | 1 | One-cycle strobe that clears the timeout flag |
| berr_out_n | output | 1 | Bus-error drive, active low |
| timeout_flag | output | 1 | Sticky flag, set when the monitor raised a bus error |

## Verification
The bench builds the block with `CLK_MHZ` = 1 and `TIMEOUT_US` = 128, which gives a limit of 128 edges. With so short a limit, every unacknowledged cycle length from 1 to 140 edges can be swept. The sweep covers both sides of the limit edge and rotates over the three data-strobe patterns. At this size the directed cases also stay short:
- a clear that lands on the timeout edge;
- an enable dropped and restored inside one cycle;
- a foreign bus error;
- strobe-only activity;
- back-to-back cycles.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

    // Control states of the cycle monitor
    typedef enum logic [1:0] {
        MON_IDLE   = 2'd0,
        MON_TIMING = 2'd1,
        MON_HOLD   = 2'd2,
        MON_BERR   = 2'd3
    } mon_state_e;

    // Clamp so that the counter always has a meaningful range
    function automatic int unsigned limit_cycles(input int unsigned us, input int unsigned mhz);
        int unsigned raw;
        raw = us * mhz;
        return (raw < 2) ? 2 : raw;
    endfunction

endpackage

// File: rtl/vmon_cycle_detect.sv
module vmon_cycle_detect #(
    parameter int unsigned NUM_DS = 2
) (
    input  logic              as_n,
    input  logic [NUM_DS-1:0] ds_n,
    input  logic              dtack_n,
    input  logic              berr_in_n,
    output logic              cycle_live,
    output logic              cycle_term
);

    logic any_ds;

    generate
        if (NUM_DS == 1) begin : g_single
            assign any_ds = ~ds_n[0];
        end else begin : g_multi
            assign any_ds = ~(&ds_n);
        end
    endgenerate

    // A cycle is open while the address strobe and some data strobe are low
    assign cycle_live = ~as_n & any_ds;
    // Either a normal acknowledge or a foreign bus error ends the cycle
    assign cycle_term = ~dtack_n | ~berr_in_n;

endmodule

// File: rtl/vmon_timer.sv
module vmon_timer #(
    parameter int unsigned LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    output logic at_limit
);

    localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // restart counts the first edge of the cycle, so load one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= CW'(1);
        end else if (advance && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/vmon_status_flag.sv
module vmon_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clear_req,
    output logic flag
);

    // A new event takes priority over a clear at the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clear_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/vme_cycle_watchdog.sv
module vme_cycle_watchdog
    import vmon_pkg::*;
#(
    parameter int unsigned NUM_DS     = 2,
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned TIMEOUT_US = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic [NUM_DS-1:0] ds_n,
    input  logic              dtack_n,
    input  logic              berr_in_n,
    input  logic              mon_enable,
    input  logic              status_clear,
    output logic              berr_out_n,
    output logic              timeout_flag
);

    localparam int unsigned LIMIT = limit_cycles(TIMEOUT_US, CLK_MHZ);

    mon_state_e state_q, state_d;
    logic cycle_live, cycle_term, at_limit;
    logic tmr_restart, tmr_advance, timeout_evt;

    vmon_cycle_detect #(.NUM_DS(NUM_DS)) i_detect (
        .as_n       (as_n),
        .ds_n       (ds_n),
        .dtack_n    (dtack_n),
        .berr_in_n  (berr_in_n),
        .cycle_live (cycle_live),
        .cycle_term (cycle_term)
    );

    vmon_timer #(.LIMIT(LIMIT)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (tmr_restart),
        .advance  (tmr_advance),
        .at_limit (at_limit)
    );

    vmon_status_flag i_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (timeout_evt),
        .clear_req (status_clear),
        .flag      (timeout_flag)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_IDLE: begin
                if (cycle_live) begin
                    if (!mon_enable || cycle_term) begin
                        state_d = MON_HOLD;
                    end else begin
                        state_d = MON_TIMING;
                    end
                end
            end
            MON_TIMING: begin
                if (!cycle_live) begin
                    state_d = MON_IDLE;
                end else if (!mon_enable || cycle_term) begin
                    state_d = MON_HOLD;
                end else if (at_limit) begin
                    state_d = MON_BERR;
                end
            end
            MON_HOLD: begin
                if (!cycle_live) begin
                    state_d = MON_IDLE;
                end
            end
            MON_BERR: begin
                if (!cycle_live) begin
                    state_d = MON_IDLE;
                end else if (!mon_enable) begin
                    state_d = MON_HOLD;
                end
            end
            default: state_d = MON_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        berr_out_n  = (state_q != MON_BERR);
        tmr_restart = (state_q == MON_IDLE) && (state_d == MON_TIMING);
        tmr_advance = (state_q == MON_TIMING);
        timeout_evt = (state_q == MON_TIMING) && (state_d == MON_BERR);
    end

endmodule

// File: rtl/vmon_checker.sv
module vmon_checker #(
    parameter int unsigned NUM_DS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic [NUM_DS-1:0] ds_n,
    input logic              dtack_n,
    input logic              berr_in_n,
    input logic              mon_enable,
    input logic              status_clear,
    input logic              berr_out_n,
    input logic              timeout_flag
);

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_enable |=> berr_out_n);

    // R4
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_out_n && (as_n || (&ds_n))) |=> berr_out_n);

    // R5
    flag_with_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(berr_out_n) |-> timeout_flag);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !status_clear) |=> timeout_flag);

    // R5
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> !berr_out_n);

    // R2
    ack_no_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && berr_out_n) |=> berr_out_n);

    // R8
    foreign_no_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_in_n && berr_out_n) |=> berr_out_n);

    // R9
    no_as_no_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> berr_out_n);

    // R6
    clear_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear && $fell(berr_out_n)) |-> timeout_flag);

endmodule

bind vme_cycle_watchdog vmon_checker #(.NUM_DS(NUM_DS)) i_vmon_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .as_n         (as_n),
    .ds_n         (ds_n),
    .dtack_n      (dtack_n),
    .berr_in_n    (berr_in_n),
    .mon_enable   (mon_enable),
    .status_clear (status_clear),
    .berr_out_n   (berr_out_n),
    .timeout_flag (timeout_flag)
);

// File: tb/test_vme_cycle_watchdog.sv
module test_vme_cycle_watchdog;

    localparam int unsigned CLK_MHZ    = 1;
    localparam int unsigned TIMEOUT_US = 128;
    localparam int          LIMIT      = CLK_MHZ * TIMEOUT_US;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       as_n;
    logic [1:0] ds_n;
    logic       dtack_n;
    logic       berr_in_n;
    logic       mon_enable;
    logic       status_clear;
    logic       berr_out_n;
    logic       timeout_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vme_cycle_watchdog #(
        .NUM_DS     (2),
        .CLK_MHZ    (CLK_MHZ),
        .TIMEOUT_US (TIMEOUT_US)
    ) i_vme_cycle_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_n         (as_n),
        .ds_n         (ds_n),
        .dtack_n      (dtack_n),
        .berr_in_n    (berr_in_n),
        .mon_enable   (mon_enable),
        .status_clear (status_clear),
        .berr_out_n   (berr_out_n),
        .timeout_flag (timeout_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance n rising edges, return at the following falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_idle();
        as_n = 1'b1; ds_n = 2'b11; dtack_n = 1'b1; berr_in_n = 1'b1;
    endtask

    task automatic clear_flag();
        status_clear = 1'b1;
        edges(1);
        status_clear = 1'b0;
    endtask

    task automatic close_cycle();
        as_n = 1'b1; ds_n = 2'b11;
        edges(1);
        dtack_n = 1'b1; berr_in_n = 1'b1;
        edges(1);
    endtask

    initial begin
        bus_idle();
        rst_n = 1'b0; mon_enable = 1'b1; status_clear = 1'b0;
        edges(3);
        check("R1 berr_out_n", berr_out_n, 1);
        check("R1 timeout_flag", timeout_flag, 0);
        rst_n = 1'b1;
        edges(1);

        // Sweep of unacknowledged lengths across the limit
        for (int n = 1; n <= LIMIT + 12; n++) begin
            logic [1:0] pat;
            int         exp_low;
            pat = (n % 3 == 0) ? 2'b00 : ((n % 3 == 1) ? 2'b10 : 2'b01);
            exp_low = (n >= LIMIT) ? 1 : 0;
            clear_flag();
            as_n = 1'b0; ds_n = pat;
            edges(n);
            check("R2/R3 berr after open edges", berr_out_n, 1 - exp_low);
            check("R5 flag with berr", timeout_flag, exp_low);
            dtack_n = 1'b0;
            edges(1);
            check("R4/R2 berr after dtack", berr_out_n, 1 - exp_low);
            as_n = 1'b1; ds_n = 2'b11;
            edges(1);
            check("R4 berr released", berr_out_n, 1);
            dtack_n = 1'b1;
            edges(1);
        end

        // R4: hold open, then release only the address strobe
        clear_flag();
        as_n = 1'b0; ds_n = 2'b00;
        edges(LIMIT + 30);
        check("R4 berr held", berr_out_n, 0);
        as_n = 1'b1;
        edges(1);
        check("R4 release on as_n", berr_out_n, 1);
        ds_n = 2'b11;
        edges(1);

        // R5: sticky over idle time, then cleared
        edges(20);
        check("R5 flag sticky", timeout_flag, 1);
        clear_flag();
        check("R5 flag cleared", timeout_flag, 0);

        // R6: clear during cycle works; clear on the timeout edge loses
        as_n = 1'b0; ds_n = 2'b01;
        edges(10);
        clear_flag();
        check("R6 early clear", timeout_flag, 0);
        edges(LIMIT - 12);
        status_clear = 1'b1;
        edges(1);
        status_clear = 1'b0;
        check("R6 berr at limit", berr_out_n, 0);
        check("R6 timeout wins over clear", timeout_flag, 1);
        close_cycle();
        clear_flag();

        // R7: disabled for a whole long cycle
        mon_enable = 1'b0;
        as_n = 1'b0; ds_n = 2'b00;
        edges(LIMIT + 5);
        check("R7 no berr when disabled", berr_out_n, 1);
        check("R7 no flag when disabled", timeout_flag, 0);
        close_cycle();
        mon_enable = 1'b1;

        // R7: disable mid-cycle then re-enable
        as_n = 1'b0; ds_n = 2'b10;
        edges(50);
        mon_enable = 1'b0;
        edges(10);
        mon_enable = 1'b1;
        edges(LIMIT + 10);
        check("R7 mid-cycle disable ends timing", berr_out_n, 1);
        check("R7 no flag after disable", timeout_flag, 0);
        close_cycle();

        // R7: disable while bus error is driven
        as_n = 1'b0; ds_n = 2'b00;
        edges(LIMIT);
        check("R7 berr before disable", berr_out_n, 0);
        mon_enable = 1'b0;
        edges(1);
        check("R7 berr dropped on disable", berr_out_n, 1);
        mon_enable = 1'b1;
        close_cycle();
        clear_flag();

        // R8: foreign bus error ends timing
        as_n = 1'b0; ds_n = 2'b00;
        edges(20);
        berr_in_n = 1'b0;
        edges(1);
        berr_in_n = 1'b1;
        edges(LIMIT + 10);
        check("R8 no monitor berr", berr_out_n, 1);
        check("R8 no flag", timeout_flag, 0);
        close_cycle();

        // R9: strobes alone are not timed
        as_n = 1'b1; ds_n = 2'b00;
        edges(LIMIT + 5);
        check("R9 ds without as", berr_out_n, 1);
        as_n = 1'b0; ds_n = 2'b11;
        edges(LIMIT + 5);
        check("R9 as without ds", berr_out_n, 1);
        check("R9 no flag", timeout_flag, 0);
        bus_idle();
        edges(1);

        // R10: back-to-back cycles each just under the limit
        for (int k = 0; k < 3; k++) begin
            as_n = 1'b0; ds_n = 2'b00;
            edges(LIMIT - 1);
            dtack_n = 1'b0;
            edges(1);
            as_n = 1'b1; ds_n = 2'b11; dtack_n = 1'b1;
            edges(1);
            check("R10 fresh timing", berr_out_n, 1);
        end
        check("R10 no flag", timeout_flag, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule